// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block watches a port of already-synchronised input pins and raises flags when a pin shows the condition its own sense mode asks for. Each pin carries a small mode code. The code selects no sensing, an active-low level, an active-high level, a rising edge, a falling edge or any change. A flag, once raised, stays set until software clears it by writing a one to its bit. The block drives one interrupt line, which is the OR of every pin's flag.

Software reaches the block through a simple word-addressed register port. A write is taken on the clock edge while the write enable is high. Reads are combinational from the address. Pin n has a control word at byte offset 4*n, and the shared status word sits above the control words. Edges are found by comparing each pin with its own value on the previous clock.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset every control field reads 0, the status word reads 0 and `irq_out` is low.
- R2: The control word for pin n is at byte offset 4*n, for n from 0 to 31. Its mode code is held in bits [19:16] and reads back from there. All other bits of the word read as 0.
- R3: Mode code 0x9 raises a pin's flag on the clock edge where the pin is 1 and was 0 on the previous edge.
- R4: Mode code 0xA raises the flag on the clock edge where the pin is 0 and was 1 on the previous edge.
- R5: Mode code 0xB raises the flag on any change of the pin between consecutive edges.
- R6: Mode code 0x8 raises the flag on every edge where the pin is 0. A clear therefore has no lasting effect while the pin stays low.
- R7: Mode code 0xC raises the flag on every edge where the pin is 1.
- R8: Mode code 0x0, and every code not listed in R3 to R7, never raises a flag. Writing 0 to a control word stops that pin from raising its flag.
- R9: The status word is at byte offset 0xA0, with bit n holding pin n's flag. Writing 1 to a bit clears that flag and writing 0 leaves it unchanged. A flag with no clear and no new event keeps its value.
- R10: When a sense event and a clear of the same bit fall on the same clock edge, the flag ends up set.
- R11: `irq_out` is high exactly when at least one status flag is set. It follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Synchronised pin levels, bit n for pin n |
| irq_out | output | 1 | Combined interrupt, the OR of all flags |

## Verification
The assertions assume that `pin_in` and the bus signals are stable around each rising clock edge. They also assume that the pins and the write strobe are low while reset is held, so that the first edge after reset has no spurious edge history. The bench meets both assumptions by changing every input on the falling clock edge and holding the pins at zero until reset is released. It then runs sweeps that give each pin a different one of all sixteen codes. Pseudo-random pin patterns, partial clears, and clears that land on the same edge as an event are applied while a cycle-accurate reference model runs in the bench.

// File: rtl/pisc_pkg.sv
package pisc_pkg;

  localparam logic [3:0] CODE_OFF    = 4'h0;
  localparam logic [3:0] CODE_LVL_LO = 4'h8;
  localparam logic [3:0] CODE_RISE   = 4'h9;
  localparam logic [3:0] CODE_FALL   = 4'hA;
  localparam logic [3:0] CODE_ANY    = 4'hB;
  localparam logic [3:0] CODE_LVL_HI = 4'hC;

  typedef enum logic [2:0] {
    SENSE_NONE,
    SENSE_LOW,
    SENSE_HIGH,
    SENSE_RISE,
    SENSE_FALL,
    SENSE_ANY
  } sense_e;

  // Map a raw mode code onto a sense type; unknown codes mean no sensing.
  function automatic sense_e decode_mode(input logic [3:0] code);
    sense_e m;
    case (code)
      CODE_LVL_LO: m = SENSE_LOW;
      CODE_LVL_HI: m = SENSE_HIGH;
      CODE_RISE:   m = SENSE_RISE;
      CODE_FALL:   m = SENSE_FALL;
      CODE_ANY:    m = SENSE_ANY;
      default:     m = SENSE_NONE;
    endcase
    return m;
  endfunction

  // Whether a pin with the given history meets the sense type this cycle.
  function automatic logic sense_hit(input sense_e m, input logic cur,
                                     input logic prev);
    logic h;
    case (m)
      SENSE_LOW:  h = ~cur;
      SENSE_HIGH: h = cur;
      SENSE_RISE: h = cur & ~prev;
      SENSE_FALL: h = ~cur & prev;
      SENSE_ANY:  h = cur ^ prev;
      default:    h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/pisc_regdec.sv
module pisc_regdec #(
  parameter int NUM_PINS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int STAT_OFS  = 'hA0,
  parameter int FIELD_LSB = 16,
  parameter int FIELD_W   = 4,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [NUM_PINS-1:0] cfg_we,
  output logic [FIELD_W-1:0]  cfg_wval,
  output logic [NUM_PINS-1:0] stat_clr,
  output logic                hit_cfg,
  output logic                hit_stat,
  output logic [IDX_W-1:0]    pin_idx
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_num;

  assign word_num = bus_addr[ADDR_W-1:2];
  assign pin_idx  = bus_addr[IDX_W+1:2];
  assign hit_cfg  = (bus_addr[1:0] == 2'b00) && (int'(word_num) < NUM_PINS);
  assign hit_stat = (bus_addr == ADDR_W'(STAT_OFS));
  assign cfg_wval = bus_wdata[FIELD_LSB +: FIELD_W];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
    assign cfg_we[g]   = bus_wr_en && hit_cfg && (int'(word_num) == g);
    assign stat_clr[g] = bus_wr_en && hit_stat && bus_wdata[g];
  end

endmodule

// File: rtl/pisc_pin_cell.sv
module pisc_pin_cell
  import pisc_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [FIELD_W-1:0] cfg_wval,
  input  logic               pin_cur,
  output logic [FIELD_W-1:0] cfg_q,
  output logic               evt,
  output logic               off
);

  logic   prev_q;
  sense_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wval;
      prev_q <= pin_cur;
    end
  end

  assign mode = decode_mode(cfg_q[3:0]);
  assign evt  = sense_hit(mode, pin_cur, prev_q);
  assign off  = (mode == SENSE_NONE);

endmodule

// File: rtl/pisc_status.sv
module pisc_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] stat_q,
  output logic                irq
);

  // A new event overrides a clear aimed at the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | evt;
  end

  assign irq = |stat_q;

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense #(
  parameter int NUM_PINS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int STAT_OFS  = 'hA0,
  parameter int FIELD_LSB = 16,
  parameter int FIELD_W   = 4,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_out
);

  logic [NUM_PINS-1:0] cfg_we;
  logic [FIELD_W-1:0]  cfg_wval;
  logic [NUM_PINS-1:0] stat_clr;
  logic                hit_cfg;
  logic                hit_stat;
  logic [IDX_W-1:0]    pin_idx;
  logic [FIELD_W-1:0]  cfg_bank [NUM_PINS];
  logic [NUM_PINS-1:0] sense_evt;
  logic [NUM_PINS-1:0] pin_off;
  logic [NUM_PINS-1:0] stat_q;

  pisc_regdec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_OFS(STAT_OFS), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
  ) u_dec (
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cfg_we(cfg_we), .cfg_wval(cfg_wval), .stat_clr(stat_clr),
    .hit_cfg(hit_cfg), .hit_stat(hit_stat), .pin_idx(pin_idx)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pisc_pin_cell #(.FIELD_W(FIELD_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[g]), .cfg_wval(cfg_wval),
      .pin_cur(pin_in[g]), .cfg_q(cfg_bank[g]), .evt(sense_evt[g]),
      .off(pin_off[g])
    );
  end

  pisc_status #(.NUM_PINS(NUM_PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(sense_evt), .clr(stat_clr),
    .stat_q(stat_q), .irq(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg) begin
      bus_rdata[FIELD_LSB +: FIELD_W] = cfg_bank[pin_idx];
    end else if (hit_stat) begin
      for (int i = 0; i < NUM_PINS; i++) bus_rdata[i] = stat_q[i];
    end
  end

endmodule

// File: rtl/pisc_chk.sv
module pisc_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] clr,
  input logic [NUM_PINS-1:0] off,
  input logic [NUM_PINS-1:0] stat,
  input logic                irq
);

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & $past(evt)) == $past(evt)); // R3
  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & off) == '0); // R8
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & $past(clr & ~evt)) == '0); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & $past(stat & ~clr)) == $past(stat & ~clr)); // R9
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(stat) & ~$past(evt)) == '0); // R8
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & $past(evt & clr)) == $past(evt & clr)); // R10
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt) != '0)); // R11
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr) != '0)); // R11

endmodule

bind pin_irq_sense pisc_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(sense_evt), .clr(stat_clr),
  .off(pin_off), .stat(stat_q), .irq(irq_out)
);

// File: tb/pin_irq_sense_tb.sv
`timescale 1ns/1ps
module pin_irq_sense_tb;

  localparam int N = 32;
  localparam logic [7:0] STAT_A = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .irq_out(irq_out)
  );

  // Reference model built from the requirements.
  logic [3:0]   m_cfg [N];
  logic [N-1:0] m_stat;
  logic [N-1:0] m_prev;

  function automatic bit ref_hit(input logic [3:0] c, input bit now, input bit was);
    if (c == 4'h8) return !now;
    if (c == 4'hC) return now;
    if (c == 4'h9) return now && !was;
    if (c == 4'hA) return was && !now;
    if (c == 4'hB) return now != was;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_cfg[i] <= 4'h0;
      m_stat <= '0;
      m_prev <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit hit, wipe;
        hit  = ref_hit(m_cfg[i], pin_in[i], m_prev[i]);
        wipe = bus_wr_en && bus_addr == STAT_A && bus_wdata[i];
        m_stat[i] <= hit | (m_stat[i] & !wipe);
        if (bus_wr_en && bus_addr[1:0] == 2'b00 && bus_addr < 8'(4 * N)
            && int'(bus_addr) / 4 == i)
          m_cfg[i] <= bus_wdata[19:16];
      end
      m_prev <= pin_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] d;
    rd(STAT_A, d);
    check(tag, d, 32'(m_stat));
    check("R11", 32'(irq_out), 32'(|m_stat));
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr;
    lfsr = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, d); check("R1", d, 32'h0);
    rd(8'h7C, d); check("R1", d, 32'h0);
    rd(STAT_A, d); check("R1", d, 32'h0);
    check("R1", 32'(irq_out), 32'h0);

    // R2: field placement and masking of other bits
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R2", d, 32'h000F_0000);
    rd(8'h10, d); check("R2", d, 32'h0);
    rd(8'h18, d); check("R2", d, 32'h0);
    wr(8'h14, 32'h0);

    // R3 directed rising edge on pin 7
    wr(8'h1C, 32'h0009_0000);
    set_pins(32'h80); chk_stat("R3");
    check("R3", 32'(m_stat), 32'h80);
    wr(STAT_A, 32'hFFFF_FFFF); chk_stat("R9");

    // R4 falling edge on pin 7
    wr(8'h1C, 32'h000A_0000);
    set_pins(32'h0); chk_stat("R4");
    check("R4", 32'(m_stat), 32'h80);
    wr(STAT_A, 32'h80);

    // R5 any change on pin 2
    wr(8'h1C, 32'h0);
    wr(8'h08, 32'h000B_0000);
    set_pins(32'h4); chk_stat("R5");
    wr(STAT_A, 32'h4); chk_stat("R5");
    set_pins(32'h0); chk_stat("R5");
    check("R5", 32'(m_stat), 32'h4);
    wr(STAT_A, 32'h4); wr(8'h08, 32'h0);

    // R6 level low on pin 3: clear does not stick while low
    wr(8'h0C, 32'h0008_0000);
    chk_stat("R6");
    wr(STAT_A, 32'h8); chk_stat("R6");
    check("R6", 32'(m_stat), 32'h8);
    set_pins(32'h8);
    wr(STAT_A, 32'h8); chk_stat("R6");
    check("R6", 32'(m_stat), 32'h0);
    wr(8'h0C, 32'h0);

    // R7 level high on pin 3
    wr(8'h0C, 32'h000C_0000);
    chk_stat("R7");
    check("R7", 32'(m_stat), 32'h8);
    wr(8'h0C, 32'h0);
    wr(STAT_A, 32'h8); chk_stat("R8");

    // R8 unlisted code and zero code never flag
    wr(8'h10, 32'h0003_0000);
    for (int k = 0; k < 4; k++) begin
      set_pins((k % 2 == 0) ? 32'h10 : 32'h0);
      chk_stat("R8");
    end
    check("R8", 32'(m_stat), 32'h0);

    // R10 edge and clear on the same edge: flag stays set
    wr(8'h04, 32'h0009_0000);
    @(negedge clk);
    pin_in = 32'h2;
    bus_wr_en = 1'b1; bus_addr = STAT_A; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk_stat("R10");
    check("R10", 32'(m_stat), 32'h2);
    wr(8'h04, 32'h0);
    wr(STAT_A, 32'hFFFF_FFFF);

    // Sweep: every pin gets a different code in each round
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < N; p++)
        wr(8'(4 * p), {12'h0, 4'((p * 3 + r) % 16), 16'hBEEF});
      rd(8'h00, d); check("R2", d, {12'h0, 4'(r % 16), 16'h0});
      rd(8'h7C, d); check("R2", d, {12'h0, 4'((93 + r) % 16), 16'h0});
      wr(STAT_A, 32'hFFFF_FFFF); chk_stat("R9");
      for (int v = 0; v < 12; v++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        set_pins(lfsr);
        chk_stat("R3/R4/R5/R6/R7/R8");
      end
      wr(STAT_A, 32'h5555_5555); chk_stat("R9");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule